// File: doc/BRIEF.md
# Dual Sequential/Target Instruction Buffer

This fetch-stage block keeps two instruction buffers, each `GROUP` entries deep, so that a wrong static prediction costs no refetch. The front end always predicts conditional branches not taken. Decode is fed only from the buffer that currently plays the sequential role, which holds the fall-through path. When a branch is seen, the block raises a request for the branch target group. The instruction cache then fills the other buffer, which plays the target role, while sequential issue goes on.

When the branch resolves as taken, the two physical buffers swap roles. The prefetched target instructions become the issue source in the very next cycle, and the old fall-through instructions are dropped. When the branch resolves as not taken, only the target buffer is emptied.

Only one branch may be outstanding at a time. A further branch seen while one is pending is stalled and must be presented again later.

Top module: `dual_ibuf`

## Requirements
- R1: After reset both buffers are empty, no branch is pending, `dec_valid` and `tgt_req_valid` are low, and `cf_ready` for the sequential destination is high.
- R2: Decode sees the instructions of the sequential-role buffer in slot order, slot 0 first (slot k is `cf_group[k*IW +: IW]`). One instruction leaves per cycle in which `dec_valid` and `dec_ready` are both high, and `dec_valid` is high exactly when that buffer is non-empty.
- R3: A fill with `cf_to_tgt`=0 targets the sequential-role buffer. `cf_ready` is high only when that buffer is empty and no resolve takes effect in the cycle. An accepted fill loads all `GROUP` entries at once, and they are visible from the next cycle.
- R4: A fill with `cf_to_tgt`=1 targets the target-role buffer. `cf_ready` is high only when a branch is pending, that buffer is empty, and no resolve takes effect in the cycle.
- R5: `br_seen` with no branch pending makes the branch pending. In the next cycle it gives a one-cycle `tgt_req_valid` pulse with `tgt_req_addr` equal to the `br_target` that was presented.
- R6: `br_seen` while a branch is pending raises `br_stall` in the same cycle. It issues no request and leaves the pending branch unchanged.
- R7: `rs_valid` with `rs_taken`=1 while a branch is pending swaps the buffer roles. From the next cycle decode issues the prefetched target instructions in slot order, with no empty cycle if they were loaded. The remaining fall-through instructions are discarded and the branch is no longer pending.
- R8: `rs_valid` with `rs_taken`=0 while a branch is pending empties the target-role buffer, clears the pending branch, and leaves sequential issue unchanged.
- R9: `rs_valid` while no branch is pending has no effect on issue order or buffer contents.
- R10: Before resolution, target-buffer instructions are never presented on `dec_instr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cf_valid | input | 1 | Cache fill group offered |
| cf_to_tgt | input | 1 | Fill destination: 0 sequential role, 1 target role |
| cf_group | input | GROUP*IW | Instruction group, slot 0 in the low bits |
| cf_ready | output | 1 | Fill accepted this cycle when high with `cf_valid` |
| br_seen | input | 1 | Conditional branch detected |
| br_target | input | AW | Address of that branch's target |
| br_stall | output | 1 | Branch refused because one is already pending |
| tgt_req_valid | output | 1 | One-cycle request to fetch the target group |
| tgt_req_addr | output | AW | Address for the target fetch |
| rs_valid | input | 1 | Branch resolution strobe |
| rs_taken | input | 1 | Resolution outcome: 1 taken (mispredicted), 0 not taken |
| dec_valid | output | 1 | Instruction available for decode |
| dec_ready | input | 1 | Decode accepts the instruction |
| dec_instr | output | IW | Instruction presented to decode |

## Verification
The bench builds the block with `GROUP`=4, `IW`=16 and `AW`=12. With these values every instruction carries a unique tag, so a mis-ordered, duplicated or stale instruction is caught at once. A four-deep buffer drains within a few cycles, so random traffic keeps hitting the states where a buffer is empty, where a resolve meets an unfilled target buffer, and where a second branch arrives while one is pending. The small address width makes request addresses easy to compare. Directed sequences cover the role swap, the not-taken flush and a resolve with nothing pending.

// File: rtl/dib_pkg.sv
package dib_pkg;

  typedef enum logic {
    DST_SEQ = 1'b0,
    DST_TGT = 1'b1
  } fill_dst_e;

  // Bank index g holds the sequential role when the role bit points at it.
  function automatic logic bank_is_seq(input logic seq_is_b, input int unsigned g);
    return (g == 1) ? seq_is_b : !seq_is_b;
  endfunction

  // Occupancy after one cycle: a fill loads a full group, a pop removes one.
  function automatic int unsigned occ_next(input int unsigned occ, input int unsigned depth,
                                           input logic fill, input logic pop, input logic drop);
    if (drop) return 0;
    if (fill) return depth;
    if (pop && occ != 0) return occ - 1;
    return occ;
  endfunction

endpackage

// File: rtl/dib_bank.sv
module dib_bank #(
  parameter int GROUP = 4,
  parameter int IW    = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  flush,
  input  logic                  wr_en,
  input  logic [GROUP*IW-1:0]   wr_group,
  input  logic                  rd_en,
  output logic [IW-1:0]         head,
  output logic [$clog2(GROUP+1)-1:0] count,
  output logic                  empty
);
  localparam int PW = (GROUP > 1) ? $clog2(GROUP) : 1;
  localparam int CW = $clog2(GROUP + 1);

  logic [IW-1:0] slots [GROUP];
  logic [PW-1:0] rd_ptr;
  logic [CW-1:0] occ;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int k = 0; k < GROUP; k++) slots[k] <= wr_group[k*IW +: IW];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ    <= '0;
      rd_ptr <= '0;
    end else begin
      occ <= CW'(dib_pkg::occ_next(int'(occ), GROUP, wr_en, rd_en, flush));
      if (flush || wr_en)         rd_ptr <= '0;
      else if (rd_en && occ != 0) rd_ptr <= rd_ptr + PW'(1);
    end
  end

  assign head  = slots[rd_ptr];
  assign count = occ;
  assign empty = (occ == '0);
endmodule

// File: rtl/dib_branch_trk.sv
module dib_branch_trk #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          br_seen,
  input  logic [AW-1:0] br_target,
  input  logic          rs_valid,
  output logic          pending,
  output logic          br_fire,
  output logic          br_stall,
  output logic          rs_fire,
  output logic          tgt_req_valid,
  output logic [AW-1:0] tgt_req_addr
);
  assign br_fire  = br_seen && !pending;
  assign br_stall = br_seen && pending;
  assign rs_fire  = rs_valid && pending;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending       <= 1'b0;
      tgt_req_valid <= 1'b0;
      tgt_req_addr  <= '0;
    end else begin
      if (rs_fire)      pending <= 1'b0;
      else if (br_fire) pending <= 1'b1;
      tgt_req_valid <= br_fire;
      if (br_fire) tgt_req_addr <= br_target;
    end
  end
endmodule

// File: rtl/dib_issue_mux.sv
module dib_issue_mux #(
  parameter int IW = 32,
  parameter int CW = 3
) (
  input  logic          seq_is_b,
  input  logic [IW-1:0] head_a,
  input  logic [IW-1:0] head_b,
  input  logic [CW-1:0] cnt_a,
  input  logic [CW-1:0] cnt_b,
  output logic [IW-1:0] seq_head,
  output logic [CW-1:0] seq_cnt,
  output logic [CW-1:0] tgt_cnt
);
  always_comb begin
    if (seq_is_b) begin
      seq_head = head_b;
      seq_cnt  = cnt_b;
      tgt_cnt  = cnt_a;
    end else begin
      seq_head = head_a;
      seq_cnt  = cnt_a;
      tgt_cnt  = cnt_b;
    end
  end
endmodule

// File: rtl/dual_ibuf.sv
module dual_ibuf #(
  parameter int GROUP = 4,
  parameter int IW    = 32,
  parameter int AW    = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cf_valid,
  input  logic                cf_to_tgt,
  input  logic [GROUP*IW-1:0] cf_group,
  output logic                cf_ready,
  input  logic                br_seen,
  input  logic [AW-1:0]       br_target,
  output logic                br_stall,
  output logic                tgt_req_valid,
  output logic [AW-1:0]       tgt_req_addr,
  input  logic                rs_valid,
  input  logic                rs_taken,
  output logic                dec_valid,
  input  logic                dec_ready,
  output logic [IW-1:0]       dec_instr
);
  localparam int CW = $clog2(GROUP + 1);

  // Named internal events, brought out for the checker.
  logic          pending, br_fire, rs_fire, cf_fire, pop;
  logic          seq_is_b;
  logic [CW-1:0] seq_cnt, tgt_cnt;
  logic [IW-1:0] seq_head;
  logic [IW-1:0] head_v [2];
  logic [CW-1:0] cnt_v  [2];
  logic [1:0]    empty_v;

  dib_branch_trk #(.AW(AW)) trk_i (
    .clk(clk), .rst_n(rst_n), .br_seen(br_seen), .br_target(br_target),
    .rs_valid(rs_valid), .pending(pending), .br_fire(br_fire),
    .br_stall(br_stall), .rs_fire(rs_fire),
    .tgt_req_valid(tgt_req_valid), .tgt_req_addr(tgt_req_addr)
  );

  assign cf_ready = !rs_fire &&
                    ((cf_to_tgt == dib_pkg::DST_TGT) ? (pending && tgt_cnt == '0)
                                                     : (seq_cnt == '0));
  assign cf_fire  = cf_valid && cf_ready;
  assign dec_valid = (seq_cnt != '0);
  assign pop       = dec_valid && dec_ready;
  assign dec_instr = seq_head;

  always_ff @(posedge clk) begin
    if (!rst_n)                  seq_is_b <= 1'b0;
    else if (rs_fire && rs_taken) seq_is_b <= !seq_is_b;
  end

  for (genvar g = 0; g < 2; g++) begin : g_bank
    logic is_seq, wr, rd, drop;
    assign is_seq = dib_pkg::bank_is_seq(seq_is_b, g);
    assign wr     = cf_fire && (cf_to_tgt ? !is_seq : is_seq);
    assign rd     = pop && is_seq;
    assign drop   = rs_fire && (rs_taken ? is_seq : !is_seq);
    dib_bank #(.GROUP(GROUP), .IW(IW)) bank_i (
      .clk(clk), .rst_n(rst_n), .flush(drop), .wr_en(wr), .wr_group(cf_group),
      .rd_en(rd), .head(head_v[g]), .count(cnt_v[g]), .empty(empty_v[g])
    );
  end

  dib_issue_mux #(.IW(IW), .CW(CW)) mux_i (
    .seq_is_b(seq_is_b), .head_a(head_v[0]), .head_b(head_v[1]),
    .cnt_a(cnt_v[0]), .cnt_b(cnt_v[1]),
    .seq_head(seq_head), .seq_cnt(seq_cnt), .tgt_cnt(tgt_cnt)
  );
endmodule

// File: rtl/dual_ibuf_chk.sv
module dual_ibuf_chk #(
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cf_valid,
  input logic          cf_ready,
  input logic          cf_to_tgt,
  input logic          br_seen,
  input logic          br_stall,
  input logic          tgt_req_valid,
  input logic          rs_valid,
  input logic          rs_taken,
  input logic          dec_valid,
  input logic          pending,
  input logic          rs_fire,
  input logic          seq_is_b,
  input logic [CW-1:0] tgt_cnt
);
  p_seq_fill_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cf_valid && cf_ready && !cf_to_tgt) |-> !dec_valid);
  p_seq_fill_visible_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cf_valid && cf_ready && !cf_to_tgt) |=> dec_valid);
  p_tgt_fill_pending_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cf_valid && cf_ready && cf_to_tgt) |-> pending);
  p_req_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (br_seen && !pending) |=> (tgt_req_valid && pending));
  p_stall_no_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    br_stall |=> !tgt_req_valid);
  p_swap_no_bubble_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_fire && rs_taken && tgt_cnt != '0) |=> dec_valid);
  p_resolve_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rs_fire |=> !pending);
  p_correct_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_fire && !rs_taken) |=> (tgt_cnt == '0));
  p_idle_resolve_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && !pending) |=> $stable(seq_is_b));
  p_resolve_no_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && pending) |-> !cf_ready);
endmodule

bind dual_ibuf dual_ibuf_chk #(.CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .cf_valid(cf_valid), .cf_ready(cf_ready),
  .cf_to_tgt(cf_to_tgt), .br_seen(br_seen), .br_stall(br_stall),
  .tgt_req_valid(tgt_req_valid), .rs_valid(rs_valid), .rs_taken(rs_taken),
  .dec_valid(dec_valid), .pending(pending), .rs_fire(rs_fire),
  .seq_is_b(seq_is_b), .tgt_cnt(tgt_cnt)
);

// File: tb/dual_ibuf_tb_top.sv
module dual_ibuf_tb_top;
  localparam int GROUP = 4;
  localparam int IW    = 16;
  localparam int AW    = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cf_valid = 0, cf_to_tgt = 0, br_seen = 0, rs_valid = 0, rs_taken = 0, dec_ready = 0;
  logic [GROUP*IW-1:0] cf_group = '0;
  logic [AW-1:0] br_target = '0;
  logic cf_ready, br_stall, tgt_req_valid, dec_valid;
  logic [AW-1:0] tgt_req_addr;
  logic [IW-1:0] dec_instr;

  always #5 clk = ~clk;

  dual_ibuf #(.GROUP(GROUP), .IW(IW), .AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cf_valid(cf_valid), .cf_to_tgt(cf_to_tgt),
    .cf_group(cf_group), .cf_ready(cf_ready), .br_seen(br_seen),
    .br_target(br_target), .br_stall(br_stall), .tgt_req_valid(tgt_req_valid),
    .tgt_req_addr(tgt_req_addr), .rs_valid(rs_valid), .rs_taken(rs_taken),
    .dec_valid(dec_valid), .dec_ready(dec_ready), .dec_instr(dec_instr)
  );

  // Behavioural reference: two queues and a pending flag.
  logic [IW-1:0] sq[$];
  logic [IW-1:0] tq[$];
  bit            m_pend = 0;
  bit            m_req_v = 0;
  logic [AW-1:0] m_req_a = '0;
  int checks = 0, errors = 0;
  int unsigned next_id = 16'h0100;
  bit done = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [GROUP*IW-1:0] make_group();
    logic [GROUP*IW-1:0] g;
    for (int k = 0; k < GROUP; k++) g[k*IW +: IW] = IW'(next_id + k);
    return g;
  endfunction

  // Compare all outputs with the model, then advance the model and one clock.
  task automatic step();
    bit rsf, exp_ready, popv;
    #1;
    rsf = rs_valid && m_pend;
    exp_ready = !rsf && (cf_to_tgt ? (m_pend && tq.size() == 0) : (sq.size() == 0));
    chk("R2 dec_valid", dec_valid, sq.size() != 0);
    if (sq.size() != 0) chk(tq.size() != 0 ? "R10 dec_instr" : "R2 dec_instr", dec_instr, sq[0]);
    chk(cf_to_tgt ? "R4 cf_ready" : "R3 cf_ready", cf_ready, exp_ready);
    chk("R6 br_stall", br_stall, br_seen && m_pend);
    chk("R5 tgt_req_valid", tgt_req_valid, m_req_v);
    if (m_req_v) chk("R5 tgt_req_addr", tgt_req_addr, m_req_a);
    // model update
    popv = (sq.size() != 0) && dec_ready;
    if (popv) void'(sq.pop_front());
    if (rsf) begin
      if (rs_taken) begin sq = tq; tq = {}; end
      else tq = {};
    end
    if (cf_valid && exp_ready) begin
      for (int k = 0; k < GROUP; k++) begin
        if (cf_to_tgt) tq.push_back(cf_group[k*IW +: IW]);
        else           sq.push_back(cf_group[k*IW +: IW]);
      end
    end
    m_req_v = br_seen && !m_pend;
    if (m_req_v) m_req_a = br_target;
    if (rsf) m_pend = 0;
    else if (br_seen && !m_pend) m_pend = 1;
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    cf_valid = 0; cf_to_tgt = 0; br_seen = 0; rs_valid = 0; rs_taken = 0; dec_ready = 0;
  endtask

  task automatic fill(input bit to_tgt);
    idle_inputs();
    cf_valid = 1; cf_to_tgt = to_tgt; cf_group = make_group(); next_id += GROUP;
    step();
    idle_inputs();
  endtask

  initial begin
    logic [IW-1:0] first_tgt, held;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    chk("R1 dec_valid", dec_valid, 0);
    chk("R1 tgt_req_valid", tgt_req_valid, 0);
    chk("R1 cf_ready", cf_ready, 1);
    chk("R1 br_stall", br_stall, 0);
    @(negedge clk);

    // Mispredict: target contents issue next cycle (R7)
    fill(0);
    br_seen = 1; br_target = 12'h3A5; step(); idle_inputs();
    br_seen = 1; br_target = 12'h111; step(); idle_inputs();   // stalled (R6)
    first_tgt = IW'(next_id);
    fill(1);
    dec_ready = 1; step(); idle_inputs();
    rs_valid = 1; rs_taken = 1; step(); idle_inputs();
    #1;
    chk("R7 no bubble", dec_valid, 1);
    chk("R7 first target", dec_instr, first_tgt);
    @(negedge clk);
    for (int i = 0; i < GROUP; i++) begin dec_ready = 1; step(); end
    idle_inputs();
    #1; chk("R7 old path discarded", dec_valid, 0); @(negedge clk);

    // Correct prediction: target flushed, sequential continues (R8)
    fill(0);
    held = sq[0];
    br_seen = 1; br_target = 12'h0C3; step(); idle_inputs();
    fill(1);
    rs_valid = 1; rs_taken = 0; step(); idle_inputs();
    #1; chk("R8 seq kept", dec_instr, held);
    cf_valid = 1; cf_to_tgt = 0; #1;
    chk("R8 seq still full", cf_ready, 0);
    idle_inputs();
    @(negedge clk);

    // Resolve with nothing pending is ignored (R9)
    rs_valid = 1; rs_taken = 1; step(); idle_inputs();
    #1; chk("R9 issue unchanged", dec_instr, held); @(negedge clk);

    // Random traffic
    for (int n = 0; n < 4000; n++) begin
      cf_valid  = ($urandom_range(0, 1) == 1);
      cf_to_tgt = ($urandom_range(0, 1) == 1);
      cf_group  = make_group(); next_id += GROUP;
      dec_ready = ($urandom_range(0, 9) < 7);
      br_seen   = ($urandom_range(0, 9) == 0);
      br_target = AW'($urandom);
      rs_valid  = ($urandom_range(0, 11) == 0);
      rs_taken  = ($urandom_range(0, 1) == 1);
      step();
    end
    idle_inputs();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule